// File: doc/BRIEF.md
# Time Code Frame Record Assembler

This block sits behind a pulse classifier in a radio-synchronised clock. Each second of a broadcast minute carries one pulse, and the classifier reports it as a coded zero, a coded one, a frame marker or an error. The block gathers the first three ten-second frames of the minute into 8-bit records. It checks that each frame is framed correctly, turns the minute and hour records from BCD into binary, and rejects values that cannot be a time of day. It then shifts the hour into the local time zone and presents the result with a one-cycle load strobe, which the clock counters use to set themselves.

If the framing breaks or the decoded values are impossible, the block drops the minute. It raises a resync request and holds it until the next minute-start strobe. Pulses after the third marker are ignored, because the later frames carry data this block does not use.

Top module: `tca_record_assembler`

## Requirements
- R1: After reset, resync is 1, load is 0, and hours and minutes are 0. Pulses that arrive before the first minute_start change none of these outputs.
- R2: A minute_start strobe clears resync at the next clock edge. It also starts frame 0 at slot 1, because second 0 of the minute carries no pulse. Slots run 0 to 9 within each frame.
- R3: pulse_cls encodes 2'b00 as zero, 2'b01 as one, 2'b10 as marker and 2'b11 as error. The minute is aborted if slot 9 holds anything other than a marker, if slot 4 holds anything other than a zero, if a marker appears in any other slot, or if any pulse is an error. An abort sets resync two clock edges after the offending pulse is sampled.
- R4: The data slots are 0, 1, 2, 3, 5, 6, 7 and 8. Each data pulse shifts the record right by one bit and inserts 1 (one) or 0 (zero) at bit 7. As a result, the first data bit lands in bit 0. Bits 3:0 are the units digit and bits 7:4 are the tens digit. Frame 1 holds the minutes and frame 2 holds the hours.
- R5: If the record of frame 0 is not all zeros when its marker arrives, the minute is aborted and resync is raised.
- R6: Two clock edges after the third marker is sampled, load pulses high for exactly one cycle, and hours and minutes take the decoded values. Pulses that follow are ignored until the next minute_start.
- R7: The result is rejected, raising resync with no load, if either BCD digit of either field is above 9, if minutes are above 59, or if hours are above 23.
- R8: The hours output is (decoded hours − (tz_num mod 24)) mod 24.
- R9: A minute_start in the middle of a minute discards all partial records and restarts collection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| minute_start | input | 1 | One-cycle strobe at the start of a minute |
| pulse_vld | input | 1 | pulse_cls is valid this cycle |
| pulse_cls | input | 2 | Pulse class: 00 zero, 01 one, 10 marker, 11 error |
| tz_num | input | 5 | Time-zone offset subtracted from the hours |
| hours | output | 5 | Local hours in binary, 0 to 23 |
| minutes | output | 6 | Minutes in binary, 0 to 59 |
| load | output | 1 | One-cycle strobe when hours and minutes are updated |
| resync | output | 1 | The minute was abandoned; wait for the next minute_start |

## Verification
The bench aims at bit order and nibble placement. A shift in the wrong direction or swapped nibbles gives wrong minutes on random times, for example 21:39 read back as 12:93. The mandatory zero in slot 4 must not be shifted in; a design that shifts it in is off by one bit in every field. Hour wrap is tested with zones of 1, 24 and 31 applied to hours near midnight. A missing modulo gives hours of 24 or more, or an underflowed value. Out-of-range values such as minute 60, hour 24 and a digit of 0xA must set resync. A design that checks only the binary value misses the bad digit. A restart in mid-minute and pulses sent after the third marker must not leak stale bits into the result or cause a second load.

// File: rtl/tca_pkg.sv
package tca_pkg;
   typedef enum logic [1:0] {
      P_ZERO = 2'b00,
      P_ONE  = 2'b01,
      P_MARK = 2'b10,
      P_ERR  = 2'b11
   } pulse_e;
endpackage

// File: rtl/tca_bcd_field.sv
module tca_bcd_field #(
   parameter int DIG_W = 4,
   parameter int MAX   = 59,
   parameter int OUT_W = 6
) (
   input  logic [2*DIG_W-1:0] rec,
   output logic [OUT_W-1:0]   val,
   output logic               ok
);
   localparam int WIDE_W = 2 * DIG_W;

   if (DIG_W < 4) begin : g_bad_dig
      $error("tca_bcd_field: DIG_W must hold a decimal digit");
   end
   if ((1 << OUT_W) <= MAX) begin : g_bad_out
      $error("tca_bcd_field: OUT_W too small for MAX");
   end

   logic [DIG_W-1:0]  units, tens;
   logic [WIDE_W-1:0] wide;

   always_comb begin
      units = rec[DIG_W-1:0];
      tens  = rec[WIDE_W-1:DIG_W];
      wide  = WIDE_W'(tens) * WIDE_W'(10) + WIDE_W'(units);
      ok    = (units <= DIG_W'(9)) && (tens <= DIG_W'(9)) && (wide <= WIDE_W'(MAX));
      val   = OUT_W'(wide);
   end
endmodule

// File: rtl/tca_frame_seq.sv
module tca_frame_seq
   import tca_pkg::*;
#(
   parameter int SLOTS     = 10,
   parameter int ZERO_SLOT = 4,
   parameter int MIN_FRAME = 1,
   parameter int HR_FRAME  = 2,
   parameter int REC_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             minute_start,
   input  logic             pulse_vld,
   input  pulse_e           cls,
   output logic [REC_W-1:0] rec_min,
   output logic [REC_W-1:0] rec_hr,
   output logic             done,
   output logic             abort
);
   localparam int SLOT_W = $clog2(SLOTS);
   localparam int FR_W   = $clog2(HR_FRAME + 1);
   localparam logic [SLOT_W-1:0] MARK_IDX = SLOT_W'(SLOTS - 1);
   localparam logic [SLOT_W-1:0] ZERO_IDX = SLOT_W'(ZERO_SLOT);

   if (ZERO_SLOT >= SLOTS - 1 || ZERO_SLOT < 1) begin : g_bad_zero
      $error("tca_frame_seq: ZERO_SLOT must lie inside the frame");
   end
   if (MIN_FRAME >= HR_FRAME || MIN_FRAME < 1) begin : g_bad_frames
      $error("tca_frame_seq: frame order must be blank, minutes, hours");
   end

   logic              active;
   logic [SLOT_W-1:0] slot;
   logic [FR_W-1:0]   frame;
   logic [REC_W-1:0]  rec;
   logic              at_mark, at_zero, bad;

   always_comb begin
      at_mark = (slot == MARK_IDX);
      at_zero = (slot == ZERO_IDX);
      if (cls == P_ERR)  bad = 1'b1;
      else if (at_mark)  bad = (cls != P_MARK) || (frame == '0 && rec != '0);
      else if (at_zero)  bad = (cls != P_ZERO);
      else               bad = (cls == P_MARK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         slot    <= '0;
         frame   <= '0;
         rec     <= '0;
         rec_min <= '0;
         rec_hr  <= '0;
         done    <= 1'b0;
         abort   <= 1'b0;
      end else begin
         done  <= 1'b0;
         abort <= 1'b0;
         if (minute_start) begin
            active <= 1'b1;
            slot   <= SLOT_W'(1);
            frame  <= '0;
            rec    <= '0;
         end else if (active && pulse_vld) begin
            if (bad) begin
               active <= 1'b0;
               abort  <= 1'b1;
            end else if (at_mark) begin
               slot  <= '0;
               rec   <= '0;
               frame <= frame + 1'b1;
               if (frame == FR_W'(MIN_FRAME)) rec_min <= rec;
               if (frame == FR_W'(HR_FRAME)) begin
                  rec_hr <= rec;
                  active <= 1'b0;
                  done   <= 1'b1;
               end
            end else begin
               slot <= slot + 1'b1;
               if (!at_zero) rec <= {cls == P_ONE, rec[REC_W-1:1]};
            end
         end
      end
   end

   // R2
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (slot <= MARK_IDX && frame <= FR_W'(HR_FRAME)));
   // R3
   done_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && abort));
   // R6
   idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !active);
endmodule

// File: rtl/tca_record_assembler.sv
module tca_record_assembler
   import tca_pkg::*;
#(
   parameter int TZ_W          = 5,
   parameter int HOURS_PER_DAY = 24,
   parameter int MIN_PER_HOUR  = 60
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               minute_start,
   input  logic                               pulse_vld,
   input  logic [1:0]                         pulse_cls,
   input  logic [TZ_W-1:0]                    tz_num,
   output logic [$clog2(HOURS_PER_DAY)-1:0]   hours,
   output logic [$clog2(MIN_PER_HOUR)-1:0]    minutes,
   output logic                               load,
   output logic                               resync
);
   localparam int DIG_W = 4;
   localparam int REC_W = 2 * DIG_W;
   localparam int HR_W  = $clog2(HOURS_PER_DAY);
   localparam int MIN_W = $clog2(MIN_PER_HOUR);
   localparam int SUM_W = HR_W + 1;

   if (HOURS_PER_DAY > 99 || MIN_PER_HOUR > 99) begin : g_bad_range
      $error("tca_record_assembler: fields hold two BCD digits");
   end

   pulse_e           cls_e;
   logic [REC_W-1:0] rec_min, rec_hr;
   logic             seq_done, seq_abort;
   logic [MIN_W-1:0] min_bin;
   logic [HR_W-1:0]  hr_bin, tz_red, hr_adj;
   logic             min_ok, hr_ok;
   logic [SUM_W-1:0] hr_sum;

   assign cls_e = pulse_e'(pulse_cls);

   tca_frame_seq #(.REC_W(REC_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .minute_start(minute_start),
      .pulse_vld(pulse_vld), .cls(cls_e),
      .rec_min(rec_min), .rec_hr(rec_hr),
      .done(seq_done), .abort(seq_abort)
   );

   tca_bcd_field #(.DIG_W(DIG_W), .MAX(MIN_PER_HOUR - 1), .OUT_W(MIN_W)) u_min (
      .rec(rec_min), .val(min_bin), .ok(min_ok)
   );
   tca_bcd_field #(.DIG_W(DIG_W), .MAX(HOURS_PER_DAY - 1), .OUT_W(HR_W)) u_hr (
      .rec(rec_hr), .val(hr_bin), .ok(hr_ok)
   );

   if ((1 << TZ_W) > HOURS_PER_DAY) begin : g_tz_mod
      assign tz_red = HR_W'(32'(tz_num) % HOURS_PER_DAY);
   end else begin : g_tz_direct
      assign tz_red = HR_W'(tz_num);
   end

   always_comb begin
      hr_sum = SUM_W'(hr_bin) + SUM_W'(HOURS_PER_DAY) - SUM_W'(tz_red);
      if (hr_sum >= SUM_W'(HOURS_PER_DAY)) hr_adj = HR_W'(hr_sum - SUM_W'(HOURS_PER_DAY));
      else                                 hr_adj = HR_W'(hr_sum);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hours   <= '0;
         minutes <= '0;
         load    <= 1'b0;
         resync  <= 1'b1;
      end else begin
         load <= 1'b0;
         if (minute_start) begin
            resync <= 1'b0;
         end else if (seq_abort) begin
            resync <= 1'b1;
         end else if (seq_done) begin
            if (min_ok && hr_ok) begin
               load    <= 1'b1;
               hours   <= hr_adj;
               minutes <= min_bin;
            end else begin
               resync <= 1'b1;
            end
         end
      end
   end

   // R7
   load_resync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && resync));
   // R8
   load_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (hours < HR_W'(HOURS_PER_DAY) && minutes < MIN_W'(MIN_PER_HOUR)));
   // R2
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      minute_start |=> !resync);
   // R6
   load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !load);
   // R6
   done_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && !minute_start) |=> (load || resync));
endmodule

// File: tb/sim_tca_record_assembler.sv
`timescale 1ns/1ps
module sim_tca_record_assembler;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       minute_start = 1'b0;
   logic       pulse_vld = 1'b0;
   logic [1:0] pulse_cls = 2'b00;
   logic [4:0] tz_num = 5'd0;
   logic [4:0] hours;
   logic [5:0] minutes;
   logic       load, resync;

   int checks = 0;
   int errors = 0;
   int load_cnt = 0;
   bit done_flag = 1'b0;

   always #4 clk = ~clk;

   tca_record_assembler u0 (
      .clk(clk), .rst_n(rst_n), .minute_start(minute_start),
      .pulse_vld(pulse_vld), .pulse_cls(pulse_cls), .tz_num(tz_num),
      .hours(hours), .minutes(minutes), .load(load), .resync(resync)
   );

   always @(negedge clk) if (load) load_cnt++;

   function automatic bit bcd_ok(input logic [7:0] r, input int maxv);
      return (r[3:0] <= 9) && (r[7:4] <= 9) && (int'(r[7:4]) * 10 + int'(r[3:0]) <= maxv);
   endfunction
   function automatic int bcd_val(input logic [7:0] r);
      return int'(r[7:4]) * 10 + int'(r[3:0]);
   endfunction
   function automatic int exp_hour(input int h, input int tz);
      return (h + 24 - (tz % 24)) % 24;
   endfunction
   function automatic logic [7:0] to_bcd(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic pulse(input logic [1:0] c);
      repeat ($urandom % 3) @(negedge clk);
      @(negedge clk);
      pulse_vld = 1'b1;
      pulse_cls = c;
      @(negedge clk);
      pulse_vld = 1'b0;
   endtask

   task automatic mstart();
      @(negedge clk);
      minute_start = 1'b1;
      @(negedge clk);
      minute_start = 1'b0;
   endtask

   // slot 9 marker, slot 4 zero, data slots 0-3 and 5-8 carry bits 0..7
   task automatic send_frame(input int f, input logic [7:0] r);
      for (int s = (f == 0) ? 1 : 0; s < 10; s++) begin
         if (s == 9)      pulse(2'b10);
         else if (s == 4) pulse(2'b00);
         else             pulse({1'b0, r[(s < 4) ? s : s - 1]});
      end
   endtask

   task automatic run_minute(input string tag, input logic [7:0] r0,
                             input logic [7:0] r1, input logic [7:0] r2);
      bit ok;
      int lc;
      ok = (r0 == 8'h00) && bcd_ok(r1, 59) && bcd_ok(r2, 23);
      mstart();
      send_frame(0, r0);
      send_frame(1, r1);
      send_frame(2, r2);
      @(negedge clk);
      check({tag, " R6 load"}, load, ok);
      check({tag, " R7 resync"}, resync, !ok);
      if (ok) begin
         check({tag, " R4 minutes"}, minutes, bcd_val(r1));
         check({tag, " R8 hours"}, hours, exp_hour(bcd_val(r2), tz_num));
      end
      @(negedge clk);
      check({tag, " R6 single load"}, load, 0);
      lc = load_cnt;
      send_frame(3, 8'($urandom));
      @(negedge clk);
      check({tag, " R6 later frames ignored"}, load_cnt, lc);
   endtask

   initial begin
      logic [7:0] r1, r2;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset resync", resync, 1);
      check("R1 reset load", load, 0);
      check("R1 reset hours", hours, 0);
      check("R1 reset minutes", minutes, 0);
      send_frame(0, 8'h00);
      send_frame(1, 8'h12);
      send_frame(2, 8'h10);
      @(negedge clk);
      check("R1 pulses before start ignored", load_cnt, 0);
      check("R1 resync held", resync, 1);

      mstart();
      check("R2 start clears resync", resync, 0);

      tz_num = 5'd0;
      run_minute("dir 21:39", 8'h00, 8'h39, 8'h21);
      run_minute("dir 23:59", 8'h00, 8'h59, 8'h23);
      tz_num = 5'd1;
      run_minute("dir tz1 midnight", 8'h00, 8'h00, 8'h00);
      tz_num = 5'd24;
      run_minute("dir tz24", 8'h00, 8'h17, 8'h05);
      tz_num = 5'd31;
      run_minute("dir tz31", 8'h00, 8'h30, 8'h03);
      tz_num = 5'd5;
      run_minute("R7 minute 60", 8'h00, 8'h60, 8'h10);
      run_minute("R7 hour 24", 8'h00, 8'h00, 8'h24);
      run_minute("R7 digit A", 8'h00, 8'h0A, 8'h10);
      run_minute("R5 frame0 nonzero", 8'h02, 8'h11, 8'h11);

      // R3 one in slot 4
      mstart();
      pulse(2'b00); pulse(2'b00); pulse(2'b00); pulse(2'b01);
      @(negedge clk);
      check("R3 slot4 not zero", resync, 1);
      // R3 error class
      mstart();
      pulse(2'b00); pulse(2'b11);
      @(negedge clk);
      check("R3 error class", resync, 1);
      // R3 marker in data slot
      mstart();
      pulse(2'b10);
      @(negedge clk);
      check("R3 marker in data slot", resync, 1);
      // R3 no marker at slot 9
      mstart();
      for (int i = 0; i < 8; i++) pulse(2'b00);
      pulse(2'b00);
      @(negedge clk);
      check("R3 missing marker", resync, 1);

      // R9 restart mid-minute
      tz_num = 5'd0;
      mstart();
      send_frame(0, 8'h00);
      pulse(2'b01); pulse(2'b01); pulse(2'b01);
      run_minute("R9 restart", 8'h00, 8'h05, 8'h07);

      for (int n = 0; n < 24; n++) begin
         tz_num = 5'($urandom % 32);
         if ($urandom % 4 != 0) begin
            r1 = to_bcd($urandom % 60);
            r2 = to_bcd($urandom % 24);
         end else begin
            r1 = 8'($urandom);
            r2 = 8'($urandom);
         end
         run_minute("rand", 8'h00, r1, r2);
      end

      done_flag = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         checks++;
         errors++;
         $display("FAIL R6 watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule